// File: doc/BRIEF.md
# CAN Operating Mode Controller

This block selects the operating mode of a CAN protocol controller. It keeps one of four modes (Configuration, Normal, Sleep, Loop Back) in a one-hot register. Each clock it moves between them on the software enable, sleep and loopback bits, a software reset, the bus idle and bus activity flags, and the pending flags of the two transmit sources. Those sources are a transmit FIFO and a high-priority transmit buffer.

Two single-cycle interrupt pulses mark entry into Sleep and exit from it. In Loop Back the block also steers the serial bit path. The bus transmit line is held recessive, and the transmitter's bit is fed back to the receiver. The bus receive line is then cut off, so frames from other nodes are never seen. Bit timing, framing, arbitration, the FIFOs and register access live in neighbouring blocks.

Top module: `can_mode_ctrl`

## Requirements
- R1: After reset, mode_o is 4'b0001 (Configuration), and sleep_irq_o and wake_irq_o are 0. The mode encoding is one-hot: bit 0 Configuration, bit 1 Normal, bit 2 Sleep, bit 3 Loop Back.
- R2: When enable_i is 0 or soft_rst_i is 1, the next mode is Configuration, from any mode. This takes priority over every other transition.
- R3: From Configuration, with enable_i=1, lback_req_i=0 and sleep_req_i=0, the next mode is Normal.
- R4: From Configuration, with enable_i=1, lback_req_i=0, sleep_req_i=1 and no tx_pend_i bit set, the next mode is Sleep. If any tx_pend_i bit is set (bit 0 FIFO, bit 1 high-priority buffer), the block stays in Configuration.
- R5: From Configuration, with enable_i=1 and lback_req_i=1, the next mode is Loop Back, whatever sleep_req_i and tx_pend_i are.
- R6: From Normal, with sleep_req_i=1, bus_idle_i=1 and no tx_pend_i bit set, the next mode is Sleep. Otherwise the block stays in Normal, and lback_req_i has no effect.
- R7: From Sleep, the next mode is Normal when sleep_req_i is 0, or bus_act_i is 1, or any tx_pend_i bit is 1.
- R8: Loop Back is left only for Configuration, and only under the condition of R2.
- R9: sleep_irq_o is high for exactly one cycle: the first cycle in which mode_o shows Sleep.
- R10: wake_irq_o is high for exactly one cycle: the first cycle after mode_o has left Sleep, to any mode.
- R11: In Loop Back, bus_tx_o is 1, rx_bit_o equals tx_bit_i, and bus_rx_i has no effect. In every other mode, bus_tx_o equals tx_bit_i and rx_bit_o equals bus_rx_i.
- R12: mode_o always has exactly one bit set, and it keeps its value in every cycle where no transition applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Controller enable bit |
| sleep_req_i | input | 1 | Sleep request bit |
| lback_req_i | input | 1 | Loop Back request bit |
| soft_rst_i | input | 1 | Software reset request |
| bus_idle_i | input | 1 | Bus is idle |
| bus_act_i | input | 1 | Bus activity detected |
| tx_pend_i | input | N_TXSRC | Pending transmit requests (bit 0 FIFO, bit 1 high-priority buffer) |
| tx_bit_i | input | 1 | Bit from the internal transmitter |
| bus_rx_i | input | 1 | Bit from the bus receive line |
| mode_o | output | 4 | One-hot mode status |
| sleep_irq_o | output | 1 | Sleep entry pulse |
| wake_irq_o | output | 1 | Sleep exit pulse |
| bus_tx_o | output | 1 | Bit to the bus transmit line |
| rx_bit_o | output | 1 | Bit to the internal receiver |

## Verification
A wrong next-mode decision shows on mode_o one clock after the inputs that caused it. The same cycle shows a missing or extra pulse on sleep_irq_o or wake_irq_o whenever Sleep is involved. A stuck or mis-encoded mode register also flips the Loop Back bit steering on bus_tx_o and rx_bit_o at once.

The bench puts the block in each of the four modes in turn. From each mode it applies all 256 combinations of the eight control inputs for one cycle. It then compares the new mode and both pulses with an expected value worked out from the transition rules. The bit steering is checked separately in Loop Back and in Normal, with every combination of the two data inputs.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;
  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    MODE_CFG = 4'b0001,
    MODE_NRM = 4'b0010,
    MODE_SLP = 4'b0100,
    MODE_LPB = 4'b1000
  } mode_e;
endpackage

// File: rtl/can_mode_next.sv
module can_mode_next
  import can_mode_pkg::*;
#(
  parameter int N_TXSRC = 2
) (
  input  mode_e              cur_i,
  input  logic               enable_i,
  input  logic               sleep_req_i,
  input  logic               lback_req_i,
  input  logic               soft_rst_i,
  input  logic               bus_idle_i,
  input  logic               bus_act_i,
  input  logic [N_TXSRC-1:0] tx_pend_i,
  output logic               cfg_cond_o,
  output mode_e              nxt_o
);
  logic any_pend;
  logic wake;

  assign any_pend   = |tx_pend_i;
  assign cfg_cond_o = !enable_i || soft_rst_i;
  assign wake       = !sleep_req_i || bus_act_i || any_pend;

  always_comb begin
    nxt_o = cur_i;
    if (cfg_cond_o) begin
      nxt_o = MODE_CFG;
    end else begin
      unique case (cur_i)
        MODE_CFG: begin
          if (lback_req_i)                 nxt_o = MODE_LPB;
          else if (!sleep_req_i)           nxt_o = MODE_NRM;
          else if (!any_pend)              nxt_o = MODE_SLP;
        end
        MODE_NRM: begin
          if (sleep_req_i && bus_idle_i && !any_pend) nxt_o = MODE_SLP;
        end
        MODE_SLP: begin
          if (wake) nxt_o = MODE_NRM;
        end
        MODE_LPB: nxt_o = MODE_LPB;
        default:  nxt_o = MODE_CFG;
      endcase
    end
  end
endmodule

// File: rtl/can_mode_irq.sv
module can_mode_irq
  import can_mode_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  mode_e cur_i,
  input  mode_e nxt_i,
  output logic  sleep_irq_o,
  output logic  wake_irq_o
);
  logic enter_slp;
  logic leave_slp;

  assign enter_slp = (cur_i != MODE_SLP) && (nxt_i == MODE_SLP);
  assign leave_slp = (cur_i == MODE_SLP) && (nxt_i != MODE_SLP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sleep_irq_o <= 1'b0;
      wake_irq_o  <= 1'b0;
    end else begin
      sleep_irq_o <= enter_slp;
      wake_irq_o  <= leave_slp;
    end
  end

  AST_SLP_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_irq_o |=> !sleep_irq_o); // R9
  AST_SLP_IRQ_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_irq_o |-> (cur_i == MODE_SLP)); // R9
  AST_WAKE_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_irq_o |=> !wake_irq_o); // R10
  AST_WAKE_IRQ_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_irq_o |-> (cur_i != MODE_SLP)); // R10
endmodule

// File: rtl/can_mode_lb.sv
module can_mode_lb
  import can_mode_pkg::*;
(
  input  mode_e cur_i,
  input  logic  tx_bit_i,
  input  logic  bus_rx_i,
  output logic  bus_tx_o,
  output logic  rx_bit_o
);
  logic lpb;

  assign lpb      = (cur_i == MODE_LPB);
  // recessive on the wire, internal loop on the receive side
  assign bus_tx_o = lpb ? 1'b1 : tx_bit_i;
  assign rx_bit_o = lpb ? tx_bit_i : bus_rx_i;
endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
  import can_mode_pkg::*;
#(
  parameter int N_TXSRC = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enable_i,
  input  logic               sleep_req_i,
  input  logic               lback_req_i,
  input  logic               soft_rst_i,
  input  logic               bus_idle_i,
  input  logic               bus_act_i,
  input  logic [N_TXSRC-1:0] tx_pend_i,
  input  logic               tx_bit_i,
  input  logic               bus_rx_i,
  output logic [MODE_W-1:0]  mode_o,
  output logic               sleep_irq_o,
  output logic               wake_irq_o,
  output logic               bus_tx_o,
  output logic               rx_bit_o
);
  mode_e mode_q;
  mode_e mode_d;
  logic  cfg_cond;

  can_mode_next #(.N_TXSRC(N_TXSRC)) u_next (
    .cur_i       (mode_q),
    .enable_i    (enable_i),
    .sleep_req_i (sleep_req_i),
    .lback_req_i (lback_req_i),
    .soft_rst_i  (soft_rst_i),
    .bus_idle_i  (bus_idle_i),
    .bus_act_i   (bus_act_i),
    .tx_pend_i   (tx_pend_i),
    .cfg_cond_o  (cfg_cond),
    .nxt_o       (mode_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_CFG;
    else         mode_q <= mode_d;
  end

  can_mode_irq u_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cur_i       (mode_q),
    .nxt_i       (mode_d),
    .sleep_irq_o (sleep_irq_o),
    .wake_irq_o  (wake_irq_o)
  );

  can_mode_lb u_lb (
    .cur_i    (mode_q),
    .tx_bit_i (tx_bit_i),
    .bus_rx_i (bus_rx_i),
    .bus_tx_o (bus_tx_o),
    .rx_bit_o (rx_bit_o)
  );

  assign mode_o = mode_q;

  AST_MODE_ONE_HOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(mode_o) == 1); // R12
  AST_CFG_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i || soft_rst_i) |=> (mode_o == MODE_CFG)); // R2
  AST_LPB_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_o == MODE_LPB) && enable_i && !soft_rst_i) |=> (mode_o == MODE_LPB)); // R8
  AST_NRM_NO_LPB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_NRM) |=> (mode_o != MODE_LPB)); // R6
  AST_SLP_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_o != MODE_SLP) && (|tx_pend_i)) |=> (mode_o != MODE_SLP)); // R4
  AST_WAKE_ON_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_o == MODE_SLP) && (|tx_pend_i)) |=> wake_irq_o); // R7
endmodule

// File: tb/sim_can_mode_ctrl.sv
module sim_can_mode_ctrl;
  localparam logic [3:0] M_CFG = 4'b0001;
  localparam logic [3:0] M_NRM = 4'b0010;
  localparam logic [3:0] M_SLP = 4'b0100;
  localparam logic [3:0] M_LPB = 4'b1000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, slp = 1'b0, lb = 1'b0, srst = 1'b0, idle = 1'b0, act = 1'b0;
  logic [1:0] pend = 2'b00;
  logic       txb = 1'b0, brx = 1'b0;
  logic [3:0] mode;
  logic       s_irq, w_irq, btx, rxb;
  int         n_chk = 0;
  int         n_fail = 0;

  always #5 clk = ~clk;

  can_mode_ctrl #(.N_TXSRC(2)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .sleep_req_i(slp),
    .lback_req_i(lb), .soft_rst_i(srst), .bus_idle_i(idle), .bus_act_i(act),
    .tx_pend_i(pend), .tx_bit_i(txb), .bus_rx_i(brx), .mode_o(mode),
    .sleep_irq_o(s_irq), .wake_irq_o(w_irq), .bus_tx_o(btx), .rx_bit_o(rxb)
  );

  task automatic check(input string tag, input logic [3:0] act_v, input logic [3:0] exp_v);
    n_chk++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act_v, exp_v);
    end
  endtask

  task automatic drive(input logic [7:0] v);
    en = v[0]; slp = v[1]; lb = v[2]; srst = v[3];
    idle = v[4]; act = v[5]; pend = v[7:6];
  endtask

  task automatic step(input logic [7:0] v);
    drive(v);
    @(posedge clk);
    @(negedge clk);
  endtask

  // controls that lead from Configuration into each mode
  task automatic set_mode(input logic [3:0] m);
    step(8'h00);
    if (m == M_NRM) step(8'b0000_0001);
    if (m == M_SLP) step(8'b0000_0011);
    if (m == M_LPB) step(8'b0000_0101);
  endtask

  function automatic logic [3:0] exp_next(input logic [3:0] c, input logic [7:0] v);
    logic e, s, l, r, i, a, p;
    e = v[0]; s = v[1]; l = v[2]; r = v[3]; i = v[4]; a = v[5]; p = v[6] | v[7];
    if (!e || r) return M_CFG;
    case (c)
      M_CFG:   return l ? M_LPB : (!s ? M_NRM : (p ? M_CFG : M_SLP));
      M_NRM:   return (s && i && !p) ? M_SLP : M_NRM;
      M_SLP:   return (!s || a || p) ? M_NRM : M_SLP;
      default: return M_LPB;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] c, input logic [7:0] v);
    if (!v[0] || v[3]) return "R2";
    case (c)
      M_CFG:   return v[2] ? "R5" : (v[1] ? "R4" : "R3");
      M_NRM:   return "R6";
      M_SLP:   return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [3:0] starts [4];
    starts = '{M_CFG, M_NRM, M_SLP, M_LPB};

    // R1 reset state
    @(negedge clk);
    @(negedge clk);
    check("R1 mode", mode, M_CFG);
    check("R1 irqs", {2'b00, s_irq, w_irq}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 mode after release", mode, M_CFG);

    // full sweep: every start mode, every control combination
    foreach (starts[k]) begin
      for (int vi = 0; vi < 256; vi++) begin
        logic [3:0] c, e;
        logic [7:0] v;
        c = starts[k];
        v = 8'(vi);
        set_mode(c);
        check("R12 start mode", mode, c);
        e = exp_next(c, v);
        step(v);
        check(tag_of(c, v), mode, e);
        check("R12 one-hot", 4'($countones(mode)), 4'd1);
        check("R9 sleep pulse", {3'b000, s_irq}, {3'b000, (c != M_SLP) && (e == M_SLP)});
        check("R10 wake pulse", {3'b000, w_irq}, {3'b000, (c == M_SLP) && (e != M_SLP)});
      end
    end

    // R9: pulse lasts one cycle while Sleep is held
    set_mode(M_SLP);
    check("R9 entry", {3'b000, s_irq}, 4'b0001);
    step(8'b0000_0011);
    check("R9 held sleep", mode, M_SLP);
    check("R9 pulse dropped", {3'b000, s_irq}, 4'b0000);
    // R10: pulse lasts one cycle after wake on bus activity
    step(8'b0010_0011);
    check("R10 wake", {3'b000, w_irq}, 4'b0001);
    step(8'b0010_0011);
    check("R10 pulse dropped", {3'b000, w_irq}, 4'b0000);
    // R12: Normal stays put with sleep request but busy bus
    step(8'b0000_0011);
    check("R12 stable normal", mode, M_NRM);

    // R11 bit steering in Loop Back and Normal
    set_mode(M_LPB);
    drive(8'b0000_0101);
    for (int b = 0; b < 4; b++) begin
      txb = b[0]; brx = b[1];
      #1;
      check("R11 lpb tx recessive", {3'b000, btx}, 4'b0001);
      check("R11 lpb rx loop", {3'b000, rxb}, {3'b000, b[0]});
    end
    set_mode(M_NRM);
    drive(8'b0000_0001);
    for (int b = 0; b < 4; b++) begin
      txb = b[0]; brx = b[1];
      #1;
      check("R11 nrm tx pass", {3'b000, btx}, {3'b000, b[0]});
      check("R11 nrm rx pass", {3'b000, rxb}, {3'b000, b[1]});
    end

    finish_run();
  end
endmodule